// File: doc/BRIEF.md
# Dual-Mode PWM Timebase Counter

This block is the period timebase for a single PWM channel. A counter runs up to a programmed period value and back, either as a sawtooth that counts downward (period to zero, then reload) or as a triangle that climbs from zero to the period and falls back again. Downstream comparators and waveform logic use the live count, a direction flag and two event pulses: one while the count sits at zero and one while it sits at the period value.

The count can advance on every system clock, or only on a single-cycle strobe from a built-in power-of-two prescaler. The design stays in one clock domain. A new period value written on the configuration port is latched only at a zero reload, so a running period is never cut short. The counting mode is also sampled at that reload point.

The control is a four-state machine. OFF holds the counter cleared. DOWN decrements. RISE increments. FALL decrements toward the bottom of a triangle. The transitions are:
- start: OFF to DOWN or RISE on enable.
- peak: RISE to FALL when the count reaches the period.
- reload: DOWN or FALL at zero, on a strobe, to DOWN or RISE by mode.
- stop: any state to OFF when enable is low.

Top module: `pwm_timebase`

## Requirements
- R1: With `use_prescale` low the count advances on every clock. With it high and `prescale_sel` = k (0..5), the count advances once every 2^(k+1) clocks. Codes 6 and 7 divide by 64. The divider restarts from zero whenever enable or `use_prescale` is low.
- R2: In count-down mode (`mode_updown` = 0) the count steps down by one per strobe from the period to zero. The following strobe reloads it with the period.
- R3: In up/down mode (`mode_updown` = 1) the count steps up by one per strobe from zero to the period. It then steps down by one per strobe to zero and repeats.
- R4: `dir` is high only while a running counter is in its rising phase. It is always low in count-down mode.
- R5: `zero_evt` is high exactly while the counter runs and the count equals zero. Its width is therefore one count period (one clock when the prescaler is bypassed).
- R6: `load_evt` is high exactly while the counter runs and the count equals the active period.
- R7: In count-down mode with a nonzero period, the strobe that ends the zero cycle puts `load_evt` high in the very next count cycle.
- R8: `load_val` is captured as the active period only at start and at a zero reload. A change mid-period does not alter the current period.
- R9: After reset, and one clock after `enable` is sampled low, `count` is 0 and `dir`, `zero_evt` and `load_evt` are low.
- R10: On the clock that samples `enable` high from the off state, the counter starts at 0. In up/down mode `dir` is then high, so counting starts upward.
- R11: With a period of 0 the count stays 0, and `zero_evt` and `load_evt` are both high on every running cycle.
- R12: A change of `mode_updown` takes effect at the next zero reload. A reload into up/down mode continues at count 1 (0 if the new period is 0). A reload into count-down mode restarts at the new period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run the counter; low clears it |
| mode_updown | input | 1 | 0 count-down, 1 up/down |
| use_prescale | input | 1 | 1 selects the prescaled count strobe |
| prescale_sel | input | 3 | Divide code, divide by 2^(code+1), capped at 64 |
| load_val | input | CNT_W | Period value, latched at zero reload |
| count | output | CNT_W | Live counter value |
| dir | output | 1 | High while counting upward |
| zero_evt | output | 1 | Count-at-zero event |
| load_evt | output | 1 | Count-at-period event |

## Verification
A sawtooth with a mid-period change of the period value separates correct shadowing from immediate loading. Triangles with an odd and an even period separate the peak and bottom turnaround from off-by-one endpoints. Prescale codes 0, 2 and 7 check both the divide ratio and the cap at 64. Runs with a period of zero in both modes check the degenerate case. A mode change, a disable and a re-enable mid-run check that modes switch only at reload and that each start begins at zero.

// File: rtl/pwm_timebase_pkg.sv
package pwm_timebase_pkg;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_DOWN = 2'd1,
        ST_RISE = 2'd2,
        ST_FALL = 2'd3
    } tb_state_e;

    localparam int unsigned PRESCALE_MAX_LOG2 = 6;

endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
    parameter int unsigned SEL_W    = 3,
    parameter int unsigned MAX_LOG2 = pwm_timebase_pkg::PRESCALE_MAX_LOG2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             use_div,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int unsigned PC_W = MAX_LOG2;

    logic [PC_W-1:0] pcnt_q;
    logic [PC_W-1:0] term;
    logic            wrap;

    // terminal value = 2^(min(sel+1, MAX_LOG2)) - 1
    always_comb begin
        int unsigned shift;
        shift = 32'(sel) + 1;
        if (shift > MAX_LOG2) begin
            shift = MAX_LOG2;
        end
        term = PC_W'((64'd1 << shift) - 64'd1);
    end

    assign wrap = (pcnt_q >= term);
    assign tick = enable && (!use_div || wrap);

    always_ff @(posedge clk) begin
        if (!rst_n || !enable || !use_div) begin
            pcnt_q <= '0;
        end else if (wrap) begin
            pcnt_q <= '0;
        end else begin
            pcnt_q <= pcnt_q + PC_W'(1);
        end
    end

    // R1: a prescaled strobe is never followed by another on the next clock
    a_r1_strobe_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && use_div && tick) |=> !(enable && use_div && tick));

endmodule

// File: rtl/pwm_period_reg.sv
module pwm_period_reg #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture,
    input  logic [CNT_W-1:0] din,
    output logic [CNT_W-1:0] period
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period <= '0;
        end else if (capture) begin
            period <= din;
        end
    end
endmodule

// File: rtl/pwm_count_fsm.sv
module pwm_count_fsm
    import pwm_timebase_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             tick,
    input  logic             mode_ud,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] period_q,
    output logic             capture,
    output logic [CNT_W-1:0] count,
    output logic             dir,
    output logic             zero_evt,
    output logic             load_evt
);
    tb_state_e        state_q, state_d;
    logic [CNT_W-1:0] count_q, count_d;
    logic             at_zero;
    logic             running;

    assign at_zero = (count_q == '0);

    // next-state process
    always_comb begin
        state_d = state_q;
        count_d = count_q;
        capture = 1'b0;
        if (!enable) begin
            state_d = ST_OFF;
            count_d = '0;
        end else if (state_q == ST_OFF) begin
            // start
            capture = 1'b1;
            count_d = '0;
            state_d = mode_ud ? ST_RISE : ST_DOWN;
        end else if (tick) begin
            if (at_zero && state_q != ST_RISE) begin
                // reload
                capture = 1'b1;
                if (mode_ud) begin
                    state_d = ST_RISE;
                    count_d = (load_val == '0) ? '0 : CNT_W'(1);
                end else begin
                    state_d = ST_DOWN;
                    count_d = load_val;
                end
            end else begin
                unique case (state_q)
                    ST_DOWN, ST_FALL: count_d = count_q - CNT_W'(1);
                    ST_RISE: begin
                        if (count_q >= period_q) begin
                            // peak
                            state_d = ST_FALL;
                            count_d = at_zero ? '0 : count_q - CNT_W'(1);
                        end else begin
                            count_d = count_q + CNT_W'(1);
                        end
                    end
                    ST_OFF: count_d = '0;
                endcase
            end
        end
    end

    // state register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            count_q <= '0;
        end else begin
            state_q <= state_d;
            count_q <= count_d;
        end
    end

    // output process
    always_comb begin
        running  = (state_q != ST_OFF);
        count    = count_q;
        dir      = (state_q == ST_RISE);
        zero_evt = running && at_zero;
        load_evt = running && (count_q == period_q);
    end

    // R2: a down step moves exactly one below the previous count
    a_r2_down_step: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && tick && state_q == ST_DOWN && !at_zero)
        |=> (count_q == $past(count_q) - CNT_W'(1)));

    // R3: a rising step below the period moves exactly one higher
    a_r3_rise_step: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && tick && state_q == ST_RISE && count_q < period_q)
        |=> (count_q == $past(count_q) + CNT_W'(1)));

    // R6: a running count never exceeds the active period
    a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (count_q <= period_q));

    // R7: in count-down mode a zero cycle ended by a strobe is followed by the load event
    a_r7_load_after_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && tick && zero_evt && state_q == ST_DOWN && !mode_ud && load_val != '0)
        |=> load_evt);

    // R8: the active period does not move while the count is away from zero
    a_r8_period_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && running && !at_zero) |=> $stable(period_q));

    // R9: a sampled disable leaves a cleared, silent counter
    a_r9_disable_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (count == '0 && !dir && !zero_evt && !load_evt));

endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
    parameter int unsigned CNT_W = 16,
    parameter int unsigned SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             mode_updown,
    input  logic             use_prescale,
    input  logic [SEL_W-1:0] prescale_sel,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count,
    output logic             dir,
    output logic             zero_evt,
    output logic             load_evt
);
    logic             tick;
    logic             capture;
    logic [CNT_W-1:0] period_q;

    pwm_prescaler #(
        .SEL_W   (SEL_W),
        .MAX_LOG2(pwm_timebase_pkg::PRESCALE_MAX_LOG2)
    ) u_prescaler (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (enable),
        .use_div(use_prescale),
        .sel    (prescale_sel),
        .tick   (tick)
    );

    pwm_period_reg #(
        .CNT_W(CNT_W)
    ) u_period (
        .clk    (clk),
        .rst_n  (rst_n),
        .capture(capture),
        .din    (load_val),
        .period (period_q)
    );

    pwm_count_fsm #(
        .CNT_W(CNT_W)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (enable),
        .tick    (tick),
        .mode_ud (mode_updown),
        .load_val(load_val),
        .period_q(period_q),
        .capture (capture),
        .count   (count),
        .dir     (dir),
        .zero_evt(zero_evt),
        .load_evt(load_evt)
    );
endmodule

// File: tb/pwm_timebase_tb.sv
module pwm_timebase_tb;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 16;
    localparam int WATCHDOG   = 20000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             enable = 1'b0;
    logic             mode_updown = 1'b0;
    logic             use_prescale = 1'b0;
    logic [2:0]       prescale_sel = 3'd0;
    logic [CNT_W-1:0] load_val = '0;
    logic [CNT_W-1:0] count;
    logic             dir, zero_evt, load_evt;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    string cur_req = "R9";

    // behavioural reference state
    bit m_run = 0, m_rising = 0;
    int m_cnt = 0, m_per = 0, m_pre = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm_timebase #(.CNT_W(CNT_W), .SEL_W(3)) u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .mode_updown(mode_updown),
        .use_prescale(use_prescale), .prescale_sel(prescale_sel), .load_val(load_val),
        .count(count), .dir(dir), .zero_evt(zero_evt), .load_evt(load_evt)
    );

    task automatic check_val(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic model_reload();
        m_per = int'(load_val);
        if (mode_updown) begin
            m_rising = 1;
            m_cnt = (m_per == 0) ? 0 : 1;
        end else begin
            m_rising = 0;
            m_cnt = m_per;
        end
    endtask

    task automatic model_step();
        int sh, lim;
        bit tk;
        sh = int'(prescale_sel) + 1;
        if (sh > 6) sh = 6;
        lim = 1 << sh;
        if (!rst_n || !enable) begin
            m_run = 0; m_rising = 0; m_cnt = 0; m_pre = 0;
            if (!rst_n) m_per = 0;
        end else begin
            tk = !use_prescale || (m_pre >= lim - 1);
            if (!use_prescale || m_pre >= lim - 1) m_pre = 0;
            else m_pre++;
            if (!m_run) begin
                m_run = 1; m_per = int'(load_val); m_cnt = 0; m_rising = mode_updown;
            end else if (tk) begin
                if (m_rising) begin
                    if (m_cnt >= m_per) begin
                        m_rising = 0;
                        if (m_cnt > 0) m_cnt--;
                    end else begin
                        m_cnt++;
                    end
                end else if (m_cnt == 0) begin
                    model_reload();
                end else begin
                    m_cnt--;
                end
            end
        end
    endtask

    task automatic compare();
        check_val(cur_req, "count", int'(count), m_cnt);
        check_val(cur_req, "dir", int'(dir), int'(m_run && m_rising));
        check_val(cur_req, "zero_evt", int'(zero_evt), int'(m_run && m_cnt == 0));
        check_val(cur_req, "load_evt", int'(load_evt), int'(m_run && m_cnt == m_per));
    endtask

    task automatic cyc(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            model_step();
            @(negedge clk);
            compare();
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R9 reset state
        cur_req = "R9";
        cyc(3);
        rst_n = 1'b1;
        cyc(2);
        check_val("R9", "reset count", int'(count), 0);

        // R2 R5 R6 R7: sawtooth, bypassed prescaler
        load_val = 16'd5;
        enable = 1'b1;
        cur_req = "R10";
        cyc(1);
        check_val("R10", "start count", int'(count), 0);
        cur_req = "R2";
        cyc(7);
        cur_req = "R7";
        check_val("R7", "load after zero", int'(load_evt), 1);
        cyc(12);

        // R8: new period mid-run
        cur_req = "R8";
        load_val = 16'd3;
        cyc(16);

        // R9: disable
        cur_req = "R9";
        enable = 1'b0;
        cyc(1);
        check_val("R9", "disabled zero_evt", int'(zero_evt), 0);
        cyc(2);

        // R3 R4 R10: triangle with even then odd period
        mode_updown = 1'b1;
        load_val = 16'd4;
        enable = 1'b1;
        cur_req = "R10";
        cyc(1);
        check_val("R10", "start dir", int'(dir), 1);
        cur_req = "R3";
        cyc(20);
        cur_req = "R4";
        load_val = 16'd3;
        cyc(20);

        // R1: prescale codes 0, 2, 7
        cur_req = "R1";
        use_prescale = 1'b1;
        prescale_sel = 3'd0;
        cyc(30);
        prescale_sel = 3'd2;
        mode_updown = 1'b0;
        cyc(80);
        prescale_sel = 3'd7;
        cyc(500);
        use_prescale = 1'b0;

        // R11: period zero in both modes
        cur_req = "R11";
        enable = 1'b0;
        load_val = 16'd0;
        cyc(1);
        enable = 1'b1;
        cyc(8);
        check_val("R11", "both events", int'(zero_evt && load_evt), 1);
        mode_updown = 1'b1;
        cyc(10);

        // R12: mode switches at reload
        cur_req = "R12";
        load_val = 16'd4;
        cyc(12);
        mode_updown = 1'b0;
        cyc(14);
        mode_updown = 1'b1;
        cyc(14);

        // R5: zero event width under a divide by 4
        cur_req = "R5";
        use_prescale = 1'b1;
        prescale_sel = 3'd1;
        cyc(60);

        finish_run();
    end
endmodule